// File: doc/BRIEF.md
# Warp Divergence Reconvergence Stack

This block keeps the thread mask of one 32-thread warp whose threads all share a single program counter. On each instruction, a lane whose mask bit is clear does not execute. When a branch splits the active threads, the warp must run each side in turn. The block handles this with a stack of saved entries. Each entry holds a 32-bit thread mask and the PC at which that saved work resumes.

On a split branch, two entries are pushed. The deeper one holds the pre-branch mask and the reconvergence PC. The upper one holds the not-taken threads and the fall-through PC. The warp then runs the taken threads at the branch target. Each sync event pops one entry and loads its mask and PC. The first pop starts the not-taken path. The second pop brings the full pre-branch mask back at the reconvergence point. So every path that at least one thread takes is run, and the paths run one after another.

A branch on which all active threads agree pushes nothing. The PC follows the common direction. Illegal events are refused without any change of state, and they set sticky error flags.

Top module: `simt_reconv_stack`

## Requirements
- R1: Reset is synchronous and active high. After reset, `active_mask` is all ones, `next_pc` equals parameter `RESET_PC` (default 0), `stack_depth` is 0, and both error flags are 0.
- R2: A branch where no active lane has its `br_taken` bit set loads `br_fallthru_pc` into `next_pc`. A branch where every active lane has its bit set loads `br_target_pc`. In both cases `active_mask` and `stack_depth` are unchanged. State updates on the clock edge that samples the event.
- R3: A split branch is one where some active lanes are taken and some are not. If at least two slots are free, it pushes two entries and raises `stack_depth` by 2. The deeper entry is {current mask, `br_reconv_pc`}. The upper entry is {current mask AND NOT taken, `br_fallthru_pc`}. It then sets `active_mask` to the current mask AND taken, and `next_pc` to `br_target_pc`.
- R4: `br_taken` bits on lanes whose `active_mask` bit is 0 have no effect. A branch never sets a mask bit that was clear.
- R5: A sync event with a non-empty stack pops the top entry. It loads that entry's mask into `active_mask` and its PC into `next_pc`, and lowers `stack_depth` by 1. After both pops of one split, the pre-branch mask returns at the reconvergence PC.
- R6: Nested splits unwind last-in first-out.
- R7: A split branch with fewer than two free slots (out of parameter `DEPTH`, default 8) changes no mask, PC or depth. It sets `overflow_err`, which stays set until reset. `stack_depth` never exceeds `DEPTH`.
- R8: A sync event with an empty stack changes no mask, PC or depth. It sets `protocol_err`, which stays set until reset.
- R9: A branch event and a sync event in the same cycle are refused: nothing changes and `protocol_err` is set.
- R10: In a cycle with no event, the mask, PC and depth hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | Branch event this cycle |
| br_taken | input | 32 | Per-lane branch direction, 1 = taken |
| br_target_pc | input | 32 | PC of the taken path |
| br_fallthru_pc | input | 32 | PC of the not-taken path |
| br_reconv_pc | input | 32 | Reconvergence PC of this branch |
| sync_valid | input | 1 | Sync (reconvergence) event this cycle |
| active_mask | output | 32 | Lanes that execute the current instruction |
| next_pc | output | 32 | PC shared by the warp |
| stack_depth | output | $clog2(DEPTH+1) | Number of saved entries |
| overflow_err | output | 1 | Sticky: a split found too little room |
| protocol_err | output | 1 | Sticky: sync on empty stack, or branch and sync together |

## Verification
The assertions check rules that hold on every cycle. The mask never gains lanes on a branch, and it is never all zero. Depth moves only by +2 on a branch and by -1 on a pop, and stays within bounds. Idle and refused cycles leave the state unchanged, and both error flags are sticky. Only the bench scenarios can show that the right entry comes back on each pop. They also show that nested splits unwind in LIFO order, and that the full mask returns at the reconvergence PC after both paths. Full overflow and random mixes of events are compared against a reference stack model.

// File: rtl/simt_stack_pkg.sv
package simt_stack_pkg;

    localparam int LANES = 32;
    localparam int PC_W  = 32;

    typedef logic [LANES-1:0] lane_mask_t;
    typedef logic [PC_W-1:0]  pc_t;

    typedef struct packed {
        lane_mask_t mask;
        pc_t        pc;
    } stack_ent_t;

    typedef enum logic [1:0] {
        BR_ALL_FALL = 2'd0,
        BR_ALL_TAKE = 2'd1,
        BR_SPLIT    = 2'd2
    } br_kind_e;

    typedef enum logic [2:0] {
        ACT_HOLD    = 3'd0,
        ACT_JUMP    = 3'd1,
        ACT_DIVERGE = 3'd2,
        ACT_POP     = 3'd3,
        ACT_REFUSE  = 3'd4
    } act_e;

    function automatic br_kind_e classify(lane_mask_t act, lane_mask_t tk);
        lane_mask_t on_tk;
        lane_mask_t off_tk;
        on_tk  = act & tk;
        off_tk = act & ~tk;
        if (on_tk == '0)
            return BR_ALL_FALL;
        else if (off_tk == '0)
            return BR_ALL_TAKE;
        else
            return BR_SPLIT;
    endfunction

endpackage

// File: rtl/simt_branch_eval.sv
module simt_branch_eval
    import simt_stack_pkg::*;
(
    input  lane_mask_t cur_mask,
    input  lane_mask_t taken,
    output lane_mask_t taken_lanes,
    output lane_mask_t other_lanes,
    output br_kind_e   kind
);
    always_comb begin
        taken_lanes = cur_mask & taken;
        other_lanes = cur_mask & ~taken;
        kind        = classify(cur_mask, taken);
    end
endmodule

// File: rtl/simt_stack_store.sv
module simt_stack_store
    import simt_stack_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int DW   = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push_pair,
    input  logic       pop,
    input  stack_ent_t ent_lo,
    input  stack_ent_t ent_hi,
    output logic [DW-1:0] depth,
    output stack_ent_t top_ent
);
    stack_ent_t slot_q [DEPTH];
    logic [DW-1:0] depth_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else if (push_pair) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (i == int'(depth_q))
                    slot_q[i] <= ent_lo;
                else if (i == int'(depth_q) + 1)
                    slot_q[i] <= ent_hi;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            depth_q <= '0;
        else if (push_pair)
            depth_q <= depth_q + DW'(2);
        else if (pop)
            depth_q <= depth_q - DW'(1);
    end

    always_comb begin
        top_ent = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (int'(depth_q) == i + 1) top_ent = slot_q[i];
        end
    end

    assign depth = depth_q;
endmodule

// File: rtl/simt_err_flags.sv
module simt_err_flags (
    input  logic clk,
    input  logic rst,
    input  logic set_ovf,
    input  logic set_proto,
    output logic ovf,
    output logic proto
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ovf   <= 1'b0;
            proto <= 1'b0;
        end else begin
            if (set_ovf)   ovf   <= 1'b1;
            if (set_proto) proto <= 1'b1;
        end
    end
endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
    import simt_stack_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter logic [31:0] RESET_PC = 32'h0,
    localparam int DW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          br_valid,
    input  logic [31:0]   br_taken,
    input  logic [31:0]   br_target_pc,
    input  logic [31:0]   br_fallthru_pc,
    input  logic [31:0]   br_reconv_pc,
    input  logic          sync_valid,
    output logic [31:0]   active_mask,
    output logic [31:0]   next_pc,
    output logic [DW-1:0] stack_depth,
    output logic          overflow_err,
    output logic          protocol_err
);
    lane_mask_t mask_q;
    pc_t        pc_q;
    lane_mask_t taken_lanes;
    lane_mask_t other_lanes;
    br_kind_e   kind;
    act_e       act;
    logic       set_ovf;
    logic       set_proto;
    logic [DW-1:0] depth;
    stack_ent_t ent_lo;
    stack_ent_t ent_hi;
    stack_ent_t top_ent;
    logic       has_room;

    simt_branch_eval u_eval (
        .cur_mask    (mask_q),
        .taken       (br_taken),
        .taken_lanes (taken_lanes),
        .other_lanes (other_lanes),
        .kind        (kind)
    );

    assign has_room = (int'(depth) + 2) <= DEPTH;

    always_comb begin
        act       = ACT_HOLD;
        set_ovf   = 1'b0;
        set_proto = 1'b0;
        if (br_valid && sync_valid) begin
            act       = ACT_REFUSE;
            set_proto = 1'b1;
        end else if (br_valid) begin
            if (kind != BR_SPLIT)
                act = ACT_JUMP;
            else if (has_room)
                act = ACT_DIVERGE;
            else
                set_ovf = 1'b1;
        end else if (sync_valid) begin
            if (depth == '0)
                set_proto = 1'b1;
            else
                act = ACT_POP;
        end
    end

    always_comb begin
        ent_lo.mask = mask_q;
        ent_lo.pc   = br_reconv_pc;
        ent_hi.mask = other_lanes;
        ent_hi.pc   = br_fallthru_pc;
    end

    simt_stack_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .push_pair (act == ACT_DIVERGE),
        .pop       (act == ACT_POP),
        .ent_lo    (ent_lo),
        .ent_hi    (ent_hi),
        .depth     (depth),
        .top_ent   (top_ent)
    );

    simt_err_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .set_ovf   (set_ovf),
        .set_proto (set_proto),
        .ovf       (overflow_err),
        .proto     (protocol_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
            pc_q   <= RESET_PC;
        end else begin
            case (act)
                ACT_JUMP:
                    pc_q <= (kind == BR_ALL_TAKE) ? br_target_pc : br_fallthru_pc;
                ACT_DIVERGE: begin
                    mask_q <= taken_lanes;
                    pc_q   <= br_target_pc;
                end
                ACT_POP: begin
                    mask_q <= top_ent.mask;
                    pc_q   <= top_ent.pc;
                end
                default: ;
            endcase
        end
    end

    assign active_mask = mask_q;
    assign next_pc     = pc_q;
    assign stack_depth = depth;
endmodule

// File: rtl/simt_reconv_stack_chk.sv
module simt_reconv_stack_chk #(
    parameter int DEPTH = 8,
    localparam int DW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          br_valid,
    input logic          sync_valid,
    input logic [31:0]   active_mask,
    input logic [31:0]   next_pc,
    input logic [DW-1:0] stack_depth,
    input logic          overflow_err,
    input logic          protocol_err
);
    AST_NO_NEW_LANES: assert property (@(posedge clk) disable iff (rst)
        (br_valid && !sync_valid) |=> ((active_mask & ~$past(active_mask)) == 32'h0)); // R4

    AST_MASK_NONZERO: assert property (@(posedge clk) disable iff (rst)
        active_mask != 32'h0); // R3

    AST_BRANCH_DEPTH: assert property (@(posedge clk) disable iff (rst)
        (br_valid && !sync_valid) |=> (stack_depth == $past(stack_depth) ||
                                       int'(stack_depth) == int'($past(stack_depth)) + 2)); // R3

    AST_POP_DEPTH: assert property (@(posedge clk) disable iff (rst)
        (sync_valid && !br_valid && stack_depth != '0) |=>
            (int'(stack_depth) + 1 == int'($past(stack_depth)))); // R5

    AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(stack_depth) <= DEPTH); // R7

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        overflow_err |=> overflow_err); // R7

    AST_EMPTY_SYNC: assert property (@(posedge clk) disable iff (rst)
        (sync_valid && !br_valid && stack_depth == '0) |=>
            ($stable(active_mask) && $stable(next_pc) && $stable(stack_depth) && protocol_err)); // R8

    AST_PERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        protocol_err |=> protocol_err); // R8

    AST_BOTH_REFUSED: assert property (@(posedge clk) disable iff (rst)
        (br_valid && sync_valid) |=>
            ($stable(active_mask) && $stable(next_pc) && $stable(stack_depth) && protocol_err)); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!br_valid && !sync_valid) |=>
            ($stable(active_mask) && $stable(next_pc) && $stable(stack_depth))); // R10
endmodule

bind simt_reconv_stack simt_reconv_stack_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .br_valid     (br_valid),
    .sync_valid   (sync_valid),
    .active_mask  (active_mask),
    .next_pc      (next_pc),
    .stack_depth  (stack_depth),
    .overflow_err (overflow_err),
    .protocol_err (protocol_err)
);

// File: tb/simt_reconv_stack_tb_top.sv
module simt_reconv_stack_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam int DW         = $clog2(DEPTH + 1);
    localparam int MAX_CYCLES = 50000;

    logic          clk = 1'b0;
    logic          rst;
    logic          br_valid;
    logic [31:0]   br_taken;
    logic [31:0]   br_target_pc;
    logic [31:0]   br_fallthru_pc;
    logic [31:0]   br_reconv_pc;
    logic          sync_valid;
    logic [31:0]   active_mask;
    logic [31:0]   next_pc;
    logic [DW-1:0] stack_depth;
    logic          overflow_err;
    logic          protocol_err;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    logic [31:0] m_mask;
    logic [31:0] m_pc;
    int          m_depth;
    logic        m_ovf;
    logic        m_perr;
    logic [31:0] m_smask [DEPTH];
    logic [31:0] m_spc   [DEPTH];

    always #(CLK_PERIOD / 2) clk = ~clk;

    simt_reconv_stack #(.DEPTH(DEPTH), .RESET_PC(32'h0)) dut_i (
        .clk            (clk),
        .rst            (rst),
        .br_valid       (br_valid),
        .br_taken       (br_taken),
        .br_target_pc   (br_target_pc),
        .br_fallthru_pc (br_fallthru_pc),
        .br_reconv_pc   (br_reconv_pc),
        .sync_valid     (sync_valid),
        .active_mask    (active_mask),
        .next_pc        (next_pc),
        .stack_depth    (stack_depth),
        .overflow_err   (overflow_err),
        .protocol_err   (protocol_err)
    );

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > MAX_CYCLES) begin
            total++;
            bad++;
            $display("FAIL watchdog: got cycles=%0d expected below %0d", cycles, MAX_CYCLES);
            summary();
        end
    end

    task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic compare_all(string tag);
        chk(tag, "active_mask", active_mask, m_mask);
        chk(tag, "next_pc", next_pc, m_pc);
        chk(tag, "stack_depth", 32'(stack_depth), 32'(m_depth));
        chk(tag, "overflow_err", 32'(overflow_err), 32'(m_ovf));
        chk(tag, "protocol_err", 32'(protocol_err), 32'(m_perr));
    endtask

    task automatic model_reset();
        m_mask = '1; m_pc = 32'h0; m_depth = 0; m_ovf = 1'b0; m_perr = 1'b0;
    endtask

    function automatic string model_step(bit b, bit s, logic [31:0] tk,
                                         logic [31:0] tg, logic [31:0] ft, logic [31:0] rc);
        logic [31:0] on_tk;
        logic [31:0] off_tk;
        on_tk  = m_mask & tk;
        off_tk = m_mask & ~tk;
        if (b && s) begin
            m_perr = 1'b1;
            return "R9";
        end else if (b) begin
            if (on_tk == 0) begin
                m_pc = ft;
                return "R2";
            end else if (off_tk == 0) begin
                m_pc = tg;
                return "R2";
            end else if (m_depth + 2 > DEPTH) begin
                m_ovf = 1'b1;
                return "R7";
            end else begin
                m_smask[m_depth] = m_mask;  m_spc[m_depth] = rc;
                m_smask[m_depth + 1] = off_tk; m_spc[m_depth + 1] = ft;
                m_depth += 2;
                m_mask = on_tk;
                m_pc = tg;
                return "R3";
            end
        end else if (s) begin
            if (m_depth == 0) begin
                m_perr = 1'b1;
                return "R8";
            end
            m_depth -= 1;
            m_mask = m_smask[m_depth];
            m_pc = m_spc[m_depth];
            return "R5";
        end
        return "R10";
    endfunction

    task automatic step(bit b, bit s, logic [31:0] tk, logic [31:0] tg,
                        logic [31:0] ft, logic [31:0] rc, string tag_override);
        string tag;
        br_valid = b; sync_valid = s; br_taken = tk;
        br_target_pc = tg; br_fallthru_pc = ft; br_reconv_pc = rc;
        tag = model_step(b, s, tk, tg, ft, rc);
        @(posedge clk);
        #1;
        br_valid = 1'b0; sync_valid = 1'b0;
        if (tag_override != "") tag = tag_override;
        compare_all(tag);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        br_valid = 1'b0; sync_valid = 1'b0; br_taken = '0;
        br_target_pc = '0; br_fallthru_pc = '0; br_reconv_pc = '0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        model_reset();
        compare_all("R1");
    endtask

    initial begin
        void'($urandom(32'd1234));
        do_reset();

        // R10: idle holds
        step(0, 0, '0, 0, 0, 0, "R10");
        // R2: uniform directions
        step(1, 0, 32'h0, 32'h100, 32'h104, 32'h200, "R2");
        step(1, 0, 32'hFFFF_FFFF, 32'h300, 32'h108, 32'h400, "R2");
        // R8: sync on empty stack
        step(0, 1, '0, 0, 0, 0, "R8");
        do_reset();

        // R3 split then R5 two pops returning full mask at reconvergence
        step(1, 0, 32'h0000_FFFF, 32'h500, 32'h504, 32'h600, "R3");
        step(0, 0, '0, 0, 0, 0, "R10");
        step(0, 1, '0, 0, 0, 0, "R5");
        step(0, 1, '0, 0, 0, 0, "R5");
        chk("R5", "full mask at reconv", active_mask, 32'hFFFF_FFFF);
        chk("R5", "reconv pc", next_pc, 32'h600);

        // R4: taken bits on inactive lanes ignored
        step(1, 0, 32'h0000_00FF, 32'h700, 32'h704, 32'h800, "R3");
        step(1, 0, 32'hFFFF_FF00, 32'h900, 32'h904, 32'hA00, "R4");
        chk("R4", "mask after inactive-only taken", active_mask, 32'h0000_00FF);
        step(1, 0, 32'hFFFF_FF0F, 32'hB00, 32'hB04, 32'hC00, "R4");

        // R6: nested LIFO unwinding
        step(0, 1, '0, 0, 0, 0, "R6");
        step(0, 1, '0, 0, 0, 0, "R6");
        step(0, 1, '0, 0, 0, 0, "R6");
        step(0, 1, '0, 0, 0, 0, "R6");
        // R9: both events together
        step(1, 1, 32'h1, 32'hD00, 32'hD04, 32'hE00, "R9");
        do_reset();

        // R7: fill stack then overflow
        step(1, 0, 32'h5555_5555, 32'h10, 32'h14, 32'h20, "R3");
        step(1, 0, 32'h1111_1111, 32'h30, 32'h34, 32'h40, "R3");
        step(1, 0, 32'h0101_0101, 32'h50, 32'h54, 32'h60, "R3");
        step(1, 0, 32'h0001_0001, 32'h70, 32'h74, 32'h80, "R3");
        step(1, 0, 32'h0000_0001, 32'h90, 32'h94, 32'hA0, "R7");
        step(0, 0, '0, 0, 0, 0, "R7");
        for (int i = 0; i < DEPTH; i++) step(0, 1, '0, 0, 0, 0, "R6");
        do_reset();

        // Random mix
        for (int n = 0; n < 600; n++) begin
            int op;
            logic [31:0] tk;
            op = int'($urandom_range(0, 99));
            case ($urandom_range(0, 3))
                0: tk = '0;
                1: tk = '1;
                default: tk = $urandom();
            endcase
            if (op < 45)
                step(1, 0, tk, $urandom(), $urandom(), $urandom(), "");
            else if (op < 85)
                step(0, 1, '0, 0, 0, 0, "");
            else if (op < 88)
                step(1, 1, tk, $urandom(), $urandom(), $urandom(), "");
            else
                step(0, 0, '0, 0, 0, 0, "");
            if (n % 150 == 149) do_reset();
        end

        summary();
    end
endmodule